// File: doc/BRIEF.md
# Strip-Mining Vector Length Sequencer

This block turns a loop trip count `n`, known only at run time, into a sequence of vector chunks. Each chunk is no longer than the machine's maximum vector length. For every chunk it presents a length and the index of the chunk's first element. A vector unit or an address generator consumes each pair and accepts it with a ready handshake. The sequencer itself performs no arithmetic on the vector data.

The odd-sized piece, `n` modulo the maximum vector length, is issued first. Every later chunk is full length, so the consumer only needs to reprogram its length once per loop. When `n` is an exact multiple of the maximum length, no empty chunk is issued and the sequence starts directly with a full chunk. A trip count of zero completes at once, with no chunks.

The maximum vector length is a parameter (64 by default). When the parameter is a power of two, the split is done with bit slicing. Otherwise a constant divider is used.

Top module: `vl_strip_seq`

## Requirements
- R1: When `n mod MAXVL` is not zero, the first chunk's `vl_len` equals `n mod MAXVL`.
- R2: Every chunk after the first has `vl_len` equal to MAXVL.
- R3: The first chunk's `vl_base` is 0. Each later chunk's `vl_base` equals the previous chunk's base plus its length.
- R4: A run issues exactly `n / MAXVL` chunks, plus one more if `n mod MAXVL` is not zero. `seq_done` rises in the cycle after the last chunk is accepted.
- R5: While `vl_valid` is high, `vl_len` is never 0 and never exceeds MAXVL.
- R6: While `vl_valid` is high and `vl_ready` is low, `vl_len` and `vl_base` hold steady. After an acceptance that is not the last one, the next chunk is valid in the very next cycle.
- R7: Starting with `n` = 0 raises `seq_done` in the next cycle, and `vl_valid` never goes high.
- R8: When `n` is a nonzero multiple of MAXVL, the first chunk already has length MAXVL. No zero-length chunk is issued.
- R9: A `go` pulse while `vl_valid` is high is ignored: the current run's chunk sequence is unchanged.
- R10: After reset, `vl_valid` and `seq_done` are both 0.
- R11: `seq_done` stays high until the next accepted `go`. The first chunk of a new run appears in the cycle after `go`, with `seq_done` low. `seq_done` and `vl_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start pulse; samples `trip_n` |
| trip_n | input | CNT_W | Total element count of the loop |
| vl_ready | input | 1 | Consumer accepts the presented chunk |
| vl_valid | output | 1 | A chunk is presented |
| vl_len | output | $clog2(MAXVL+1) | Length of the presented chunk |
| vl_base | output | CNT_W | First element index of the presented chunk |
| seq_done | output | 1 | All chunks of the run have been accepted |

## Verification
Trip counts are chosen to separate the ways the split can go. Zero separates the empty-run path. One and MAXVL-1 exercise a single remainder-only chunk. Exact multiples of MAXVL show that no empty chunk is produced. Counts with both a remainder and several full chunks check the ordering and the base stepping. A stalled ready pattern checks that each chunk holds steady and that no chunk is skipped. A stray start pulse in the middle of a run, and a restart after completion, check that runs stay separate.

// File: rtl/vl_strip_pkg.sv
package vl_strip_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_EMIT = 2'd1,
        PH_DONE = 2'd2
    } seq_phase_t;

    function automatic bit is_pow2(input int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/vl_split.sv
module vl_split #(
    parameter int MAXVL = 64,
    parameter int CNT_W = 16,
    localparam int LEN_W = $clog2(MAXVL + 1)
) (
    input  logic [CNT_W-1:0] n_val,
    output logic [LEN_W-1:0] rem,
    output logic [CNT_W-1:0] quot
);
    import vl_strip_pkg::*;

    localparam logic [CNT_W-1:0] MAXN = CNT_W'(MAXVL);

    generate
        if (is_pow2(MAXVL)) begin : g_pow2
            localparam int SH = $clog2(MAXVL);
            localparam logic [CNT_W-1:0] MASK = MAXN - 1'b1;
            always_comb begin
                rem  = LEN_W'(n_val & MASK);
                quot = n_val >> SH;
            end
        end else begin : g_div
            logic [CNT_W-1:0] rem_full;
            always_comb begin
                rem_full = n_val % MAXN;
                rem      = LEN_W'(rem_full);
                quot     = n_val / MAXN;
            end
        end
    endgenerate
endmodule

// File: rtl/vl_chunk_count.sv
module vl_chunk_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             is_zero
);
    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)
            left_q <= '0;
        else if (load)
            left_q <= load_val;
        else if (dec && left_q != '0)
            left_q <= left_q - 1'b1;
    end

    assign is_zero = (left_q == '0);
endmodule

// File: rtl/vl_base_acc.sv
module vl_base_acc #(
    parameter int CNT_W = 16,
    parameter int LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    input  logic [LEN_W-1:0] step_len,
    output logic [CNT_W-1:0] base
);
    always_ff @(posedge clk) begin
        if (rst || clear)
            base <= '0;
        else if (step)
            base <= base + CNT_W'(step_len);
    end
endmodule

// File: rtl/vl_strip_seq.sv
module vl_strip_seq #(
    parameter int MAXVL = 64,
    parameter int CNT_W = 16,
    localparam int LEN_W = $clog2(MAXVL + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [CNT_W-1:0] trip_n,
    input  logic             vl_ready,
    output logic             vl_valid,
    output logic [LEN_W-1:0] vl_len,
    output logic [CNT_W-1:0] vl_base,
    output logic             seq_done
);
    import vl_strip_pkg::*;

    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(MAXVL);

    seq_phase_t       phase_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] rem;
    logic [CNT_W-1:0] quot;
    logic [CNT_W-1:0] later_cnt;
    logic             take_go;
    logic             accept;
    logic             last_chunk;

    assign take_go = go && (phase_q != PH_EMIT);
    assign accept  = (phase_q == PH_EMIT) && vl_ready;
    // full chunks that follow the first one
    assign later_cnt = (rem == '0) ? quot - 1'b1 : quot;

    vl_split #(.MAXVL(MAXVL), .CNT_W(CNT_W)) u_split (
        .n_val (trip_n),
        .rem   (rem),
        .quot  (quot)
    );

    vl_chunk_count #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (take_go),
        .load_val (later_cnt),
        .dec      (accept),
        .is_zero  (last_chunk)
    );

    vl_base_acc #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_base (
        .clk      (clk),
        .rst      (rst),
        .clear    (take_go),
        .step     (accept),
        .step_len (len_q),
        .base     (vl_base)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            len_q   <= '0;
        end else if (take_go) begin
            if (trip_n == '0) begin
                phase_q <= PH_DONE;
            end else begin
                phase_q <= PH_EMIT;
                len_q   <= (rem != '0) ? rem : FULL_LEN;
            end
        end else if (accept) begin
            if (last_chunk)
                phase_q <= PH_DONE;
            else
                len_q <= FULL_LEN;
        end
    end

    assign vl_valid = (phase_q == PH_EMIT);
    assign seq_done = (phase_q == PH_DONE);
    assign vl_len   = len_q;

    // R5
    a_r5_len_bound: assert property (@(posedge clk) disable iff (rst)
        vl_valid |-> (vl_len != '0 && vl_len <= FULL_LEN));

    // R6
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (vl_valid && !vl_ready) |=> (vl_valid && $stable(vl_len) && $stable(vl_base)));

    // R3
    a_r3_base_step: assert property (@(posedge clk) disable iff (rst)
        (vl_valid && vl_ready) |=>
            (!vl_valid || vl_base == $past(vl_base) + CNT_W'($past(vl_len))));

    // R2
    a_r2_full_after: assert property (@(posedge clk) disable iff (rst)
        (vl_valid && vl_ready) |=> (!vl_valid || vl_len == FULL_LEN));

    // R11
    a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(vl_valid && seq_done));

    // R7
    a_r7_zero_trip: assert property (@(posedge clk) disable iff (rst)
        (go && !vl_valid && trip_n == '0) |=> (seq_done && !vl_valid));
endmodule

// File: tb/sim_vl_strip_seq.sv
module sim_vl_strip_seq;
    localparam int MAXVL = 64;
    localparam int CNT_W = 16;
    localparam int LEN_W = $clog2(MAXVL + 1);

    logic             clk = 1'b0;
    logic             rst;
    logic             go;
    logic [CNT_W-1:0] trip_n;
    logic             vl_ready;
    logic             vl_valid;
    logic [LEN_W-1:0] vl_len;
    logic [CNT_W-1:0] vl_base;
    logic             seq_done;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    vl_strip_seq #(.MAXVL(MAXVL), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .go(go), .trip_n(trip_n), .vl_ready(vl_ready),
        .vl_valid(vl_valid), .vl_len(vl_len), .vl_base(vl_base), .seq_done(seq_done)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Runs one trip count. stall_mod>0 holds ready low on every cycle whose
    // index mod stall_mod is nonzero. stray_go pulses go mid-run with another n.
    task automatic run_trip(input int n, input int stall_mod, input bit stray_go);
        int rem_e   = n % MAXVL;
        int count_e = n / MAXVL + ((rem_e != 0) ? 1 : 0);
        int seen    = 0;
        int exp_base = 0;
        int cyc     = 0;
        int prev_len = 0;
        int prev_base = 0;
        bit prev_stall = 0;
        bit prev_acc = 0;
        @(negedge clk);
        trip_n = CNT_W'(n);
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        trip_n = '0;
        chk("R11 done low after go", int'(seq_done), (n == 0) ? 1 : 0);
        if (n == 0)
            chk("R7 no chunk for zero trip", int'(vl_valid), 0);
        else
            chk("R11 first chunk valid after go", int'(vl_valid), 1);
        while (!seq_done && cyc < 5000) begin
            if (prev_stall) begin
                chk("R6 len held", int'(vl_len), prev_len);
                chk("R6 base held", int'(vl_base), prev_base);
            end
            if (prev_acc && seen < count_e)
                chk("R6 next chunk follows", int'(vl_valid), 1);
            if (vl_valid) begin
                chk("R5 len bound", int'(vl_len >= 1 && vl_len <= MAXVL), 1);
                chk("R11 not done with valid", int'(seq_done), 0);
            end
            vl_ready = (stall_mod == 0) || (cyc % stall_mod == 0);
            if (stray_go && cyc == 2) begin
                go = 1'b1;
                trip_n = 16'd7;
            end
            prev_stall = vl_valid && !vl_ready;
            prev_acc   = vl_valid && vl_ready;
            prev_len   = int'(vl_len);
            prev_base  = int'(vl_base);
            if (vl_valid && vl_ready) begin
                if (seen == 0)
                    chk((rem_e != 0) ? "R1 first len" : "R8 first len full",
                        int'(vl_len), (rem_e != 0) ? rem_e : MAXVL);
                else
                    chk("R2 later len", int'(vl_len), MAXVL);
                chk("R3 base", int'(vl_base), exp_base);
                exp_base += int'(vl_len);
                seen++;
            end
            @(negedge clk);
            go = 1'b0;
            vl_ready = 1'b0;
            cyc++;
        end
        chk("R4 chunk count", seen, count_e);
        chk("R4 done raised", int'(seq_done), 1);
        chk("R9 total covered", exp_base, n);
        @(negedge clk);
        chk("R11 done holds", int'(seq_done), 1);
        chk("R11 no valid while done", int'(vl_valid), 0);
    endtask

    task automatic test_reset();
        rst = 1'b1; go = 1'b0; trip_n = '0; vl_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 valid after reset", int'(vl_valid), 0);
        chk("R10 done after reset", int'(seq_done), 0);
    endtask

    initial begin
        test_reset();
        run_trip(0, 0, 0);        // R7
        run_trip(1, 0, 0);        // R1
        run_trip(63, 0, 0);       // R1
        run_trip(64, 0, 0);       // R8
        run_trip(128, 0, 0);      // R8, R2
        run_trip(130, 0, 0);      // R1, R2, R3
        run_trip(200, 3, 0);      // R6 stalls
        run_trip(150, 2, 1);      // R9 stray go
        run_trip(65, 0, 0);       // R11 restart after done
        run_trip(0, 0, 0);        // R7 after a run
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule